// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a host register port and the serial shift engine of an SPI controller. It holds a transmit queue that the host fills and the shift engine drains, and a receive queue that the shift engine fills and the host drains. Each queue holds 16 words. A packed status word reports the fill level of each queue along with a full or empty indication. A configurable threshold drives a pair of "level reached" events.

Queue events and transfer-completion events are kept as sticky flags in two separate flag registers. Each flag register has its own enable register, and both are cleared by writing ones. A single interrupt line is raised while any flag and its matching enable bit are both set. Writing a word into a full transmit queue is recorded as an overflow error. Reading from an empty receive queue is recorded as an underrun error.

The host drives one register access per cycle. Write data takes effect at the clock edge that samples it. Read data is registered and appears on `reg_rdata` after the edge that samples `reg_rd`.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Register map on the 4-bit `reg_addr`:
  - 0x0 control (write only): bit 0 empties the transmit queue, bit 1 empties the receive queue.
  - 0x1 threshold code in bits 1:0, readable.
  - 0x2 transmit data (write pushes).
  - 0x3 receive data (read pops).
  - 0x4 status.
  - 0x5 queue-event flags.
  - 0x6 queue-event enables.
  - 0x7 transfer flags.
  - 0x8 transfer enables.
  
  After reset both queues are empty, the threshold code is 0, all enables are 0, `irq` is 0, `tx_valid` is 0, and status reads 0x00100000.
- R2: The status word has transmit full at bit 4, transmit level at bits 15:8, receive empty at bit 20 and receive level at bits 31:24. The transmit queue holds 16 words and presents them on `tx_word` in write order, one per `tx_pop`. `tx_valid` is high while the queue is not empty.
- R3: Each `rx_push` stores `rx_word` in the receive queue. Host reads of 0x3 return the stored words in arrival order.
- R4: A write to 0x2 while the transmit queue is full drops the word and sets queue flag bit 17.
- R5: A read of 0x3 while the receive queue is empty returns 0 and sets queue flag bit 16.
- R6: The threshold code selects a threshold of 8 entries for code 0, 4 for code 1, 1 for code 2 and 8 for code 3. Queue flag bit 5 sets while the transmit level is at or below the threshold. Queue flag bit 4 sets while the receive level is at or above the threshold.
- R7: Queue flag bit 8 sets while the receive queue holds 16 words. Queue flag bit 9 sets while the transmit queue is empty.
- R8: A pulse on `rx_done_evt` sets transfer flag bit 0. A pulse on `tx_done_evt` sets transfer flag bit 1.
- R9: All flags are sticky. Writing a 1 to a bit of 0x5 or 0x7 clears that flag. A set condition in the same cycle as the clear wins.
- R10: `irq` is high exactly when some flag and its enable bit are both 1. Only the implemented flag bits of an enable register are stored and read back, so 0x6 reads back at most 0x00030330 and 0x8 at most 0x3. Zero in both enable registers holds `irq` low.
- R11: A control write with bit 0 set empties the transmit queue, and one with bit 1 set empties the receive queue. Both take effect at the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered host read data |
| tx_pop | input | 1 | Shift engine takes the transmit head word |
| tx_word | output | 32 | Transmit head word |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_word | input | 32 | Received word |
| rx_done_evt | input | 1 | Receive-complete event pulse |
| tx_done_evt | input | 1 | Transmit-complete event pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
Queue levels, the status word, `tx_word` and `tx_valid` follow a push or pop at the same edge that samples it. Level-derived flags and error flags land one edge later, because they are computed from the registered levels and request strobes. Read data is due one edge after the read strobe, and `irq` follows the flag or enable registers without further delay. The bench therefore leaves at least one idle edge between a stimulus and the read that observes its flags. The scoreboard compares `reg_rdata` at the falling edge after the read strobe was sampled, and `irq` and `tx_word` are checked at the falling edge after the update.

// File: rtl/sfi_pkg.sv
`timescale 1ns/1ps
package sfi_pkg;

    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        A_CTRL   = 4'h0,
        A_CFG    = 4'h1,
        A_TXDATA = 4'h2,
        A_RXDATA = 4'h3,
        A_STATUS = 4'h4,
        A_QFLAG  = 4'h5,
        A_QEN    = 4'h6,
        A_XFLAG  = 4'h7,
        A_XEN    = 4'h8
    } reg_addr_e;

    // queue-event flag positions
    localparam int QB_RXTHR = 4;
    localparam int QB_TXTHR = 5;
    localparam int QB_RXFUL = 8;
    localparam int QB_TXEMP = 9;
    localparam int QB_RXUND = 16;
    localparam int QB_TXOVF = 17;
    // transfer-event flag positions
    localparam int XB_RXDONE = 0;
    localparam int XB_TXDONE = 1;

    localparam logic [REG_W-1:0] QFLAG_MASK = REG_W'(32'h0003_0330);
    localparam logic [REG_W-1:0] XFLAG_MASK = REG_W'(32'h0000_0003);

    // status word positions
    localparam int SB_TXFULL = 4;
    localparam int SB_TXLVL  = 8;
    localparam int SB_RXEMP  = 20;
    localparam int SB_RXLVL  = 24;

    typedef struct packed {
        logic [1:0]       thr_code;
        logic [REG_W-1:0] rdata;
    } unit_state_t;

    function automatic int thr_entries(input logic [1:0] code);
        case (code)
            2'd1:    return 4;
            2'd2:    return 1;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/sfi_fifo.sv
`timescale 1ns/1ps
module sfi_fifo #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (st_q.cnt == LW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign level = st_q.cnt;
    assign head  = mem[st_q.rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (do_push) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (do_pop)  st_d.rd_ptr = bump(st_q.rd_ptr);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= wdata;
    end

endmodule

// File: rtl/sfi_flag_bank.sv
`timescale 1ns/1ps
module sfi_flag_bank #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags,
    output logic [W-1:0] enables,
    output logic         hit
);

    typedef struct packed {
        logic [W-1:0] flg;
        logic [W-1:0] en;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = clr_we ? wdata : '0;
        // set beats clear in the same cycle
        st_d.flg = ((st_q.flg & ~clr_mask) | set_evt) & IMPL;
        if (en_we) st_d.en = wdata & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags   = st_q.flg;
    assign enables = st_q.en;
    assign hit     = |(st_q.flg & st_q.en);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit
    import sfi_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int DATA_W = 32,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_valid,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_done_evt,
    input  logic              tx_done_evt,
    output logic              irq
);

    unit_state_t st_d, st_q;

    logic [LW-1:0]     tx_level, rx_level, thr_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              tx_wr, rx_rd, ctrl_we, cfg_we;
    logic              qclr_we, qen_we, xclr_we, xen_we;
    logic [REG_W-1:0]  q_set, x_set, q_flags, q_en, x_flags, x_en;
    logic              q_hit, x_hit;
    logic [REG_W-1:0]  status_word, rd_mux;

    // host access decode
    always_comb begin
        tx_wr   = reg_wr && (reg_addr == A_TXDATA);
        rx_rd   = reg_rd && (reg_addr == A_RXDATA);
        ctrl_we = reg_wr && (reg_addr == A_CTRL);
        cfg_we  = reg_wr && (reg_addr == A_CFG);
        qclr_we = reg_wr && (reg_addr == A_QFLAG);
        qen_we  = reg_wr && (reg_addr == A_QEN);
        xclr_we = reg_wr && (reg_addr == A_XFLAG);
        xen_we  = reg_wr && (reg_addr == A_XEN);
    end

    sfi_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctrl_we && reg_wdata[0]),
        .push  (tx_wr),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (tx_pop),
        .head  (tx_word),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfi_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctrl_we && reg_wdata[1]),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_rd),
        .head  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_valid = !tx_empty;

    // event sources
    always_comb begin
        thr_lvl          = LW'(thr_entries(st_q.thr_code));
        q_set            = '0;
        q_set[QB_RXTHR]  = (rx_level >= thr_lvl);
        q_set[QB_TXTHR]  = (tx_level <= thr_lvl);
        q_set[QB_RXFUL]  = rx_full;
        q_set[QB_TXEMP]  = tx_empty;
        q_set[QB_RXUND]  = rx_rd && rx_empty;
        q_set[QB_TXOVF]  = tx_wr && tx_full;
        x_set            = '0;
        x_set[XB_RXDONE] = rx_done_evt;
        x_set[XB_TXDONE] = tx_done_evt;
    end

    sfi_flag_bank #(.W(REG_W), .IMPL(QFLAG_MASK)) u_qflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (q_set),
        .clr_we  (qclr_we),
        .en_we   (qen_we),
        .wdata   (reg_wdata),
        .flags   (q_flags),
        .enables (q_en),
        .hit     (q_hit)
    );

    sfi_flag_bank #(.W(REG_W), .IMPL(XFLAG_MASK)) u_xflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (x_set),
        .clr_we  (xclr_we),
        .en_we   (xen_we),
        .wdata   (reg_wdata),
        .flags   (x_flags),
        .enables (x_en),
        .hit     (x_hit)
    );

    assign irq = q_hit || x_hit;

    // status word and read path
    always_comb begin
        status_word                       = '0;
        status_word[SB_TXFULL]            = tx_full;
        status_word[SB_TXLVL +: 8]        = 8'(tx_level);
        status_word[SB_RXEMP]             = rx_empty;
        status_word[SB_RXLVL +: 8]        = 8'(rx_level);
        case (reg_addr)
            A_CFG:    rd_mux = REG_W'(st_q.thr_code);
            A_RXDATA: rd_mux = rx_empty ? '0 : REG_W'(rx_head);
            A_STATUS: rd_mux = status_word;
            A_QFLAG:  rd_mux = q_flags;
            A_QEN:    rd_mux = q_en;
            A_XFLAG:  rd_mux = x_flags;
            A_XEN:    rd_mux = x_en;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.thr_code = reg_wdata[1:0];
        if (reg_rd) st_d.rdata    = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/sfi_checker.sv
`timescale 1ns/1ps
module sfi_checker
    import sfi_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [LW-1:0]    tx_level,
    input logic [LW-1:0]    rx_level,
    input logic             tx_full,
    input logic             rx_empty,
    input logic [REG_W-1:0] q_flags,
    input logic [REG_W-1:0] x_flags,
    input logic [REG_W-1:0] q_en,
    input logic [REG_W-1:0] x_en,
    input logic             tx_done_evt,
    input logic             irq
);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    // R4
    tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXDATA && tx_full) |=> q_flags[QB_TXOVF]);

    // R4
    overflow_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXDATA && tx_full) |=> (tx_level != '0));

    // R5
    rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RXDATA && rx_empty)
        |=> (reg_rdata == '0) && q_flags[QB_RXUND]);

    // R8
    tx_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_evt |=> x_flags[XB_TXDONE]);

    // R9
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flags[QB_TXOVF] && !(reg_wr && reg_addr == A_QFLAG && reg_wdata[QB_TXOVF]))
        |=> q_flags[QB_TXOVF]);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en == '0 && x_en == '0) |-> !irq);

    // R11
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0]) |=> (tx_level == '0));

endmodule

bind spi_fifo_irq_unit sfi_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .tx_full     (tx_full),
    .rx_empty    (rx_empty),
    .q_flags     (q_flags),
    .x_flags     (x_flags),
    .q_en        (q_en),
    .x_en        (x_en),
    .tx_done_evt (tx_done_evt),
    .irq         (irq)
);

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_done_evt = 1'b0, tx_done_evt = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    spi_fifo_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_word(tx_word), .tx_valid(tx_valid),
        .rx_push(rx_push), .rx_word(rx_word),
        .rx_done_evt(rx_done_evt), .tx_done_evt(tx_done_evt), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard for register reads
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] sb_exp;
    string       sb_tag;

    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                sb_exp = exp_q.pop_front();
                sb_tag = tag_q.pop_front();
                chk(sb_tag, reg_rdata, sb_exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_pop(input logic [31:0] e, input string tag);
        @(negedge clk);
        chk(tag, tx_word, e);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_word = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        rd(4'h4, 32'h0010_0000, "R1 status after reset");
        rd(4'h1, 32'h0, "R1 threshold code after reset");
        rd(4'h6, 32'h0, "R1 queue enables after reset");
        rd(4'h5, 32'h0000_0220, "R7 tx empty and R6 tx threshold flags");
        rd(4'h7, 32'h0, "R8 transfer flags idle");

        // R2 fill transmit queue
        for (int i = 0; i < 16; i++) wr(4'h2, 32'hA0 + i);
        rd(4'h4, 32'h0010_1010, "R2 status full level 16");
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0, "R9 clear all queue flags");
        // R4 overflow
        wr(4'h2, 32'h0000_DEAD);
        rd(4'h5, 32'h0002_0000, "R4 overflow flag");
        rd(4'h4, 32'h0010_1010, "R4 level unchanged");
        for (int i = 0; i < 16; i++) eng_pop(32'hA0 + i, "R2 transmit order");
        @(negedge clk);
        chk("R4 dropped word not queued", {31'b0, tx_valid}, 32'h0);

        // R9 set beats clear
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0000_0220, "R9 set wins over clear");

        // R6 threshold code 1
        wr(4'h1, 32'h1);
        rd(4'h1, 32'h1, "R6 threshold code readback");
        eng_push(32'h11); eng_push(32'h22); eng_push(32'h33);
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0000_0220, "R6 rx level 3 below threshold 4");
        eng_push(32'h44);
        rd(4'h5, 32'h0000_0230, "R6 rx level 4 reaches threshold 4");
        for (int i = 0; i < 5; i++) wr(4'h2, 32'h50 + i);
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0000_0010, "R6 tx level 5 above threshold 4");
        eng_pop(32'h50, "R2 transmit head");
        rd(4'h5, 32'h0000_0030, "R6 tx level 4 at threshold 4");
        wr(4'h0, 32'h1);
        rd(4'h4, 32'h0400_0000, "R11 tx flush keeps rx level 4");

        // R3 receive order, R6 code 2
        rd(4'h3, 32'h11, "R3 receive order 0");
        rd(4'h3, 32'h22, "R3 receive order 1");
        rd(4'h3, 32'h33, "R3 receive order 2");
        wr(4'h1, 32'h2);
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0000_0230, "R6 rx level 1 at threshold 1");
        rd(4'h3, 32'h44, "R3 receive order 3");
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h5, 32'h0000_0220, "R6 rx level 0 below threshold 1");
        // R5 underrun
        rd(4'h3, 32'h0, "R5 empty read returns zero");
        rd(4'h5, 32'h0001_0220, "R5 underrun flag");

        // R7 receive full, then R11 flush
        wr(4'h1, 32'h1);
        wr(4'h5, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) eng_push(32'h100 + i);
        rd(4'h5, 32'h0000_0330, "R7 rx full flag");
        rd(4'h4, 32'h1000_0000, "R3 rx level 16");
        wr(4'h0, 32'h3);
        rd(4'h4, 32'h0010_0000, "R11 both queues flushed");

        // R8 transfer events
        @(negedge clk); rx_done_evt = 1'b1; @(negedge clk); rx_done_evt = 1'b0;
        rd(4'h7, 32'h1, "R8 rx complete flag");
        @(negedge clk); tx_done_evt = 1'b1; @(negedge clk); tx_done_evt = 1'b0;
        rd(4'h7, 32'h3, "R8 tx complete flag");
        chk("R10 irq low with no enables", {31'b0, irq}, 32'h0);
        wr(4'h8, 32'h2);
        chk("R10 irq from enabled tx complete", {31'b0, irq}, 32'h1);
        wr(4'h7, 32'h2);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        rd(4'h7, 32'h1, "R9 clear one transfer flag");
        // R9 set beats clear on the transfer register
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h7; reg_wdata = 32'h3; tx_done_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_done_evt = 1'b0;
        rd(4'h7, 32'h2, "R9 transfer set wins over clear");
        chk("R10 irq high again", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h0);
        chk("R10 irq low when enables zero", {31'b0, irq}, 32'h0);
        wr(4'h6, 32'h0000_0200);
        chk("R10 irq from tx empty", {31'b0, irq}, 32'h1);
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'h6, 32'h0003_0330, "R10 queue enable implemented bits");
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, 32'h0000_0003, "R10 transfer enable implemented bits");
        wr(4'h6, 32'h0);
        wr(4'h8, 32'h0);
        chk("R10 irq silenced", {31'b0, irq}, 32'h0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule